// File: doc/BRIEF.md
# Shared Timebase with Per-Core Compare Alarms

This block keeps one free-running up-counter that every core in a cluster reads as its common timebase. The counter width is chosen at build time as 32 plus four times a width code. Software reads that code back from a read-only field, and a halt bit in the same register freezes and resumes counting. Each core owns a 64-bit alarm value. When the counter equals a core's alarm value, that core's timer interrupt line asserts and stays asserted until the alarm value is written again.

All software access goes through one word-wide register port. Every access carries the index of the requesting core. A core reads the 64-bit count as two 32-bit words, upper word first: reading the upper word captures the lower word in a per-core holding register, so the two reads form one coherent value. A core reaches its own alarm value through a local pair of half-word registers. It reaches any other core's alarm value by first storing that core's index in its peer-select register and then using a second, remote pair of registers. Read data appears one cycle after the read strobe.

Top module: `glb_timer`

## Requirements
- R1: After reset the counter is 0 and running. Every alarm value is all ones, every interrupt line is low, the read data is 0, every peer-select register is 0 and every holding register is 0.
- R2: The configuration register is at address 0x0. Bit 0 is the halt bit and can be read and written. Bits 7:4 read as the width code and ignore writes. All other bits read as 0. The counter holds 32+4*code bits.
- R3: While the halt bit is clear, the counter advances by exactly one each clock. While the halt bit is set, the counter holds its value, and counting resumes when the bit is cleared.
- R4: Address 0x2 reads counter bits 63:32, with bits at or above the counter width reading as 0. The same read stores counter bits 31:0 in the requesting core's holding register. Address 0x1 returns that holding register, so its value does not change until the same core reads 0x2 again.
- R5: Addresses 0x4 (bits 31:0) and 0x5 (bits 63:32) write and read the requesting core's own alarm value.
- R6: Address 0x3 holds the requesting core's peer index in bits CORE_W-1:0. Addresses 0x6 (bits 31:0) and 0x7 (bits 63:32) write and read the alarm value of the core that this peer index names.
- R7: A core index of NUM_CORES or above, whether it is the requester or the peer, makes alarm writes through that path have no effect and makes reads through that path return 0.
- R8: A core's interrupt line rises on the clock edge after the counter equals that core's alarm value. It stays high after the counter moves past the alarm value.
- R9: Writing either half of a core's alarm value, by either path, drives that core's interrupt line low on the same edge. The new alarm value is then compared again from the next cycle on.
- R10: A read at address A places A's value on acc_rdata at the next clock edge. acc_rdata keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_core | input | CORE_W | Index of the core making the access |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_addr | input | 4 | Word address of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered |
| tick_irq | output | NUM_CORES | Per-core latched alarm interrupt |

## Verification
The hardest state to reach is an exact equality between a moving counter and an alarm value at a known cycle, together with proof that the interrupt stays latched after the counter passes it. The bench halts the counter and reads the frozen value. It then writes that value into an alarm, which gives an immediate match. Next it moves the alarm a few counts ahead, releases the halt and watches the line rise and then stay high. The remote path reuses the frozen count to fire another core's alarm from core 0. The bench also aims a peer index at a core that does not exist and confirms that no alarm value changes.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

  localparam logic [3:0] RA_CFG     = 4'h0;
  localparam logic [3:0] RA_CNT_LO  = 4'h1;
  localparam logic [3:0] RA_CNT_HI  = 4'h2;
  localparam logic [3:0] RA_SEL     = 4'h3;
  localparam logic [3:0] RA_CMP_LO  = 4'h4;
  localparam logic [3:0] RA_CMP_HI  = 4'h5;
  localparam logic [3:0] RA_RCMP_LO = 4'h6;
  localparam logic [3:0] RA_RCMP_HI = 4'h7;

  localparam int CFG_HALT_BIT  = 0;
  localparam int CFG_WIDTH_LSB = 4;

  typedef logic [63:0] gt_word64_t;

  function automatic int gt_cnt_width(input int code);
    return 32 + 4 * code;
  endfunction

endpackage

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             halt_wdata,
  output logic             halt_q,
  output logic [CNT_W-1:0] cnt_q
);

  logic             halt_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    halt_d = halt_q;
    if (cfg_wr) halt_d = halt_wdata;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!halt_q) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      halt_q <= halt_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/gtmr_cmp_slot.sv
module gtmr_cmp_slot #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [63:0]      cmp_q,
  output logic             hit,
  output logic             irq
);

  logic [63:0] cmp_d;
  logic        irq_d;
  logic        any_wr;

  assign any_wr = wr_lo | wr_hi;
  assign hit    = (64'(cnt_q) == cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[31:0]  = wdata;
    if (wr_hi) cmp_d[63:32] = wdata;
  end

  always_comb begin
    irq_d = irq | hit;
    if (any_wr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      irq   <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      irq   <= irq_d;
    end
  end

endmodule

// File: rtl/gtmr_regif.sv
module gtmr_regif
  import gtmr_pkg::*;
#(
  parameter int NUM_CORES  = 3,
  parameter int CORE_W     = 2,
  parameter int CNT_W      = 48,
  parameter int WIDTH_CODE = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CORE_W-1:0]             req_core,
  input  logic                          acc_wr,
  input  logic                          acc_rd,
  input  logic [3:0]                    acc_addr,
  input  logic [CORE_W-1:0]             sel_wdata,
  input  logic [CNT_W-1:0]              cnt_q,
  input  logic                          halt_q,
  input  logic [NUM_CORES-1:0][63:0]    cmp_all,
  output logic                          cfg_wr,
  output logic [NUM_CORES-1:0]          cmp_wr_lo,
  output logic [NUM_CORES-1:0]          cmp_wr_hi,
  output logic [31:0]                   acc_rdata
);

  logic [CORE_W-1:0] sel_q  [NUM_CORES];
  logic [CORE_W-1:0] sel_d  [NUM_CORES];
  logic [31:0]       snap_q [NUM_CORES];
  logic [31:0]       snap_d [NUM_CORES];
  logic [31:0]       rdata_d;

  logic              req_ok;
  logic              rem_ok;
  logic [CORE_W-1:0] own_sel;
  logic [31:0]       own_snap;
  gt_word64_t        own_cmp;
  gt_word64_t        rem_cmp;
  gt_word64_t        cnt64;

  assign cnt64  = 64'(cnt_q);
  assign cfg_wr = acc_wr && (acc_addr == RA_CFG);

  // Requester lookup by comparison, so an index past NUM_CORES never selects.
  always_comb begin
    req_ok   = 1'b0;
    own_sel  = '0;
    own_snap = '0;
    own_cmp  = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (req_core == CORE_W'(i)) begin
        req_ok   = 1'b1;
        own_sel  = sel_q[i];
        own_snap = snap_q[i];
        own_cmp  = cmp_all[i];
      end
    end
  end

  always_comb begin
    rem_ok  = 1'b0;
    rem_cmp = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (req_ok && (own_sel == CORE_W'(i))) begin
        rem_ok  = 1'b1;
        rem_cmp = cmp_all[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++) begin
      cmp_wr_lo[i] = acc_wr &&
        (((acc_addr == RA_CMP_LO)  && req_ok && (req_core == CORE_W'(i))) ||
         ((acc_addr == RA_RCMP_LO) && rem_ok && (own_sel  == CORE_W'(i))));
      cmp_wr_hi[i] = acc_wr &&
        (((acc_addr == RA_CMP_HI)  && req_ok && (req_core == CORE_W'(i))) ||
         ((acc_addr == RA_RCMP_HI) && rem_ok && (own_sel  == CORE_W'(i))));
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++) begin
      sel_d[i]  = sel_q[i];
      snap_d[i] = snap_q[i];
      if (acc_wr && (acc_addr == RA_SEL) && (req_core == CORE_W'(i)))
        sel_d[i] = sel_wdata;
      if (acc_rd && (acc_addr == RA_CNT_HI) && (req_core == CORE_W'(i)))
        snap_d[i] = cnt64[31:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (acc_addr)
      RA_CFG: begin
        rdata_d[CFG_HALT_BIT]                    = halt_q;
        rdata_d[CFG_WIDTH_LSB +: 4]              = 4'(WIDTH_CODE);
      end
      RA_CNT_LO:  rdata_d = own_snap;
      RA_CNT_HI:  rdata_d = cnt64[63:32];
      RA_SEL:     rdata_d = 32'(own_sel);
      RA_CMP_LO:  rdata_d = own_cmp[31:0];
      RA_CMP_HI:  rdata_d = own_cmp[63:32];
      RA_RCMP_LO: rdata_d = rem_cmp[31:0];
      RA_RCMP_HI: rdata_d = rem_cmp[63:32];
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CORES; i++) begin
        sel_q[i]  <= '0;
        snap_q[i] <= '0;
      end
      acc_rdata <= '0;
    end else begin
      for (int i = 0; i < NUM_CORES; i++) begin
        sel_q[i]  <= sel_d[i];
        snap_q[i] <= snap_d[i];
      end
      if (acc_rd) acc_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/glb_timer.sv
module glb_timer
  import gtmr_pkg::*;
#(
  parameter int NUM_CORES  = 3,
  parameter int WIDTH_CODE = 4,
  parameter int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CORE_W-1:0]    req_core,
  input  logic                 acc_wr,
  input  logic                 acc_rd,
  input  logic [3:0]           acc_addr,
  input  logic [31:0]          acc_wdata,
  output logic [31:0]          acc_rdata,
  output logic [NUM_CORES-1:0] tick_irq
);

  localparam int CNT_W = gt_cnt_width(WIDTH_CODE);

  logic                       cfg_wr;
  logic                       halt_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [NUM_CORES-1:0]       cmp_wr_lo;
  logic [NUM_CORES-1:0]       cmp_wr_hi;
  logic [NUM_CORES-1:0]       cmp_wr_any;
  logic [NUM_CORES-1:0]       cmp_hit;
  logic [NUM_CORES-1:0][63:0] cmp_all;

  assign cmp_wr_any = cmp_wr_lo | cmp_wr_hi;

  gtmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .halt_wdata (acc_wdata[CFG_HALT_BIT]),
    .halt_q     (halt_q),
    .cnt_q      (cnt_q)
  );

  gtmr_regif #(
    .NUM_CORES  (NUM_CORES),
    .CORE_W     (CORE_W),
    .CNT_W      (CNT_W),
    .WIDTH_CODE (WIDTH_CODE)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_core  (req_core),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_addr  (acc_addr),
    .sel_wdata (acc_wdata[CORE_W-1:0]),
    .cnt_q     (cnt_q),
    .halt_q    (halt_q),
    .cmp_all   (cmp_all),
    .cfg_wr    (cfg_wr),
    .cmp_wr_lo (cmp_wr_lo),
    .cmp_wr_hi (cmp_wr_hi),
    .acc_rdata (acc_rdata)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    gtmr_cmp_slot #(.CNT_W(CNT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (cmp_wr_lo[c]),
      .wr_hi (cmp_wr_hi[c]),
      .wdata (acc_wdata),
      .cnt_q (cnt_q),
      .cmp_q (cmp_all[c]),
      .hit   (cmp_hit[c]),
      .irq   (tick_irq[c])
    );
  end

endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker #(
  parameter int NUM_CORES  = 3,
  parameter int CNT_W      = 48,
  parameter int WIDTH_CODE = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_rd,
  input logic [3:0]           acc_addr,
  input logic [31:0]          acc_rdata,
  input logic [CNT_W-1:0]     cnt_val,
  input logic                 cnt_halt,
  input logic [NUM_CORES-1:0] cmp_wr,
  input logic [NUM_CORES-1:0] cmp_hit,
  input logic [NUM_CORES-1:0] tick_irq
);

  p_width_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && (acc_addr == 4'h0)) |=> (acc_rdata[7:4] == 4'(WIDTH_CODE)));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_halt |=> $stable(cnt_val));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_halt |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

  p_set_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick_irq & ~$past(tick_irq) & ~$past(cmp_hit)) == '0));

  p_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(tick_irq) & ~$past(cmp_wr) & ~tick_irq) == '0));

  p_clear_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr != '0) |=> ((tick_irq & $past(cmp_wr)) == '0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(acc_rdata));

endmodule

bind glb_timer gtmr_checker #(
  .NUM_CORES  (NUM_CORES),
  .CNT_W      (CNT_W),
  .WIDTH_CODE (WIDTH_CODE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_rd    (acc_rd),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata),
  .cnt_val   (cnt_q),
  .cnt_halt  (halt_q),
  .cmp_wr    (cmp_wr_any),
  .cmp_hit   (cmp_hit),
  .tick_irq  (tick_irq)
);

// File: tb/glb_timer_tb_top.sv
module glb_timer_tb_top;

  localparam int NC = 3;
  localparam int CW = 2;

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] req_core;
  logic          acc_wr;
  logic          acc_rd;
  logic [3:0]    acc_addr;
  logic [31:0]   acc_wdata;
  logic [31:0]   acc_rdata;
  logic [NC-1:0] tick_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  glb_timer #(.NUM_CORES(NC), .WIDTH_CODE(4)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_core  (req_core),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .tick_irq  (tick_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [CW-1:0] core, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_core = core; acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic do_read(input logic [CW-1:0] core, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req_core = core; acc_addr = a; acc_rd = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata;
  endtask

  task automatic read_count(input logic [CW-1:0] core, output logic [31:0] hi, output logic [31:0] lo);
    do_read(core, 4'h2, hi);
    do_read(core, 4'h1, lo);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(tick_irq == '0, "R1 irq after reset", 32'(tick_irq), 0);
    check(acc_rdata == 0, "R1 rdata after reset", acc_rdata, 0);
    do_read(0, 4'h5, v);
    check(v == 32'hFFFF_FFFF, "R1 alarm hi reset", v, 32'hFFFF_FFFF);
    do_read(1, 4'h4, v);
    check(v == 32'hFFFF_FFFF, "R1 alarm lo reset", v, 32'hFFFF_FFFF);
    do_read(2, 4'h3, v);
    check(v == 0, "R1 peer select reset", v, 0);
    do_read(1, 4'h1, v);
    check(v == 0, "R1 holding register reset", v, 0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    do_read(0, 4'h0, v);
    check(v == 32'h40, "R2 config reset value", v, 32'h40);
    do_write(1, 4'h0, 32'hFFFF_FFF1);
    do_read(2, 4'h0, v);
    check(v == 32'h41, "R2 halt set, width read-only", v, 32'h41);
    do_write(0, 4'h0, 32'h0);
    do_read(0, 4'h0, v);
    check(v == 32'h40, "R2 halt cleared", v, 32'h40);
  endtask

  task automatic t_count;
    logic [31:0] h, a, b, c, d;
    read_count(0, h, a);
    check(h == 0, "R4 upper word zero", h, 0);
    read_count(0, h, b);
    check(b - a == 4, "R3 advance by one per clock", b - a, 4);
    do_write(0, 4'h0, 32'h1);
    read_count(0, h, a);
    repeat (10) @(negedge clk);
    read_count(0, h, b);
    check(a == b, "R3 frozen while halted", b, a);
    do_write(0, 4'h0, 32'h0);
    read_count(0, h, c);
    read_count(0, h, d);
    check(c > b, "R3 resumes after halt", c, b);
    check(d - c == 4, "R3 resumed rate", d - c, 4);
  endtask

  task automatic t_snapshot;
    logic [31:0] h, l1, l2, l3;
    read_count(1, h, l1);
    repeat (20) @(negedge clk);
    do_read(1, 4'h1, l2);
    check(l2 == l1, "R4 low word held until upper read", l2, l1);
    read_count(1, h, l3);
    check(l3 > l1, "R4 upper read refreshes low word", l3, l1);
  endtask

  task automatic t_local_alarm;
    logic [31:0] h, v, r;
    do_write(1, 4'h0, 32'h1);
    read_count(1, h, v);
    do_write(1, 4'h5, 32'h0);
    do_write(1, 4'h4, v);
    check(tick_irq == '0, "R9 line low on write edge", 32'(tick_irq), 0);
    @(negedge clk);
    check(tick_irq == 3'b010, "R8 line rises after match", 32'(tick_irq), 32'h2);
    do_read(1, 4'h4, r);
    check(r == v, "R5 local alarm low readback", r, v);
    do_read(1, 4'h5, r);
    check(r == 0, "R5 local alarm high readback", r, 0);
    do_write(1, 4'h4, v + 5);
    check(tick_irq[1] == 1'b0, "R9 rewrite clears line", 32'(tick_irq), 0);
    repeat (3) @(negedge clk);
    check(tick_irq[1] == 1'b0, "R9 no match while halted", 32'(tick_irq), 0);
    do_write(1, 4'h0, 32'h0);
    repeat (12) @(negedge clk);
    check(tick_irq == 3'b010, "R8 fires when counter reaches alarm", 32'(tick_irq), 32'h2);
    repeat (20) @(negedge clk);
    check(tick_irq[1] == 1'b1, "R8 stays latched past alarm", 32'(tick_irq), 32'h2);
    do_write(1, 4'h4, 32'hFFFF_FFFF);
    check(tick_irq == '0, "R9 cleanup write clears line", 32'(tick_irq), 0);
  endtask

  task automatic t_remote;
    logic [31:0] h, w, r;
    do_write(0, 4'h0, 32'h1);
    read_count(0, h, w);
    do_write(0, 4'h3, 32'h2);
    do_read(0, 4'h3, r);
    check(r == 2, "R6 peer select readback", r, 2);
    do_write(0, 4'h7, 32'h0);
    do_write(0, 4'h6, w);
    @(negedge clk);
    check(tick_irq == 3'b100, "R6 remote alarm fires peer line", 32'(tick_irq), 32'h4);
    do_read(2, 4'h4, r);
    check(r == w, "R6 peer sees remote low write", r, w);
    do_read(2, 4'h5, r);
    check(r == 0, "R6 peer sees remote high write", r, 0);
    do_read(0, 4'h6, r);
    check(r == w, "R6 remote window readback", r, w);
    do_read(0, 4'h4, r);
    check(r == 32'hFFFF_FFFF, "R6 requester alarm untouched", r, 32'hFFFF_FFFF);
    do_write(2, 4'h4, w + 100);
    check(tick_irq == '0, "R9 peer rewrite clears line", 32'(tick_irq), 0);
  endtask

  task automatic t_invalid(input logic [31:0] w);
    logic [31:0] r;
    do_write(0, 4'h3, 32'h3);
    do_write(0, 4'h6, 32'h1234);
    do_read(0, 4'h6, r);
    check(r == 0, "R7 absent peer reads zero", r, 0);
    do_read(1, 4'h4, r);
    check(r == 32'hFFFF_FFFF, "R7 core1 alarm unchanged", r, 32'hFFFF_FFFF);
    do_read(2, 4'h4, r);
    check(r == w, "R7 core2 alarm unchanged", r, w);
    do_write(3, 4'h4, 32'h55);
    do_read(3, 4'h4, r);
    check(r == 0, "R7 absent requester reads zero", r, 0);
    do_read(0, 4'h4, r);
    check(r == 32'hFFFF_FFFF, "R7 core0 alarm unchanged", r, 32'hFFFF_FFFF);
  endtask

  task automatic t_rdata_hold;
    logic [31:0] r;
    do_read(0, 4'h0, r);
    do_write(1, 4'h5, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    check(acc_rdata == r, "R10 read data held between reads", acc_rdata, r);
  endtask

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; acc_wr = 1'b0; acc_rd = 1'b0;
    acc_addr = '0; acc_wdata = '0; req_core = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_count();
    t_snapshot();
    t_local_alarm();
    t_remote();
    do_read(2, 4'h4, w);
    t_invalid(w);
    t_rdata_hold();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule